// File: doc/BRIEF.md
# Direction-Gated Serial Master

This block moves single bytes between a local host and one serial coprocessor, such as a security or cipher chip. The coprocessor signals which way data may flow on a busy line. A high level means it will accept data. A low level means it has data to return. The host places either a write request with a byte or a read request. The block holds that request until the busy level allows that direction, then runs one 8-bit frame.

The serial side always uses clock polarity 0 and phase 0. The clock rests low. Both ends sample on the rising edge and change data on the falling edge. Bits go most significant first. The serial clock is the system clock divided by `2*DIV`. Chip select is active low and frames each transfer with half a serial period of margin on each side. A minimum idle gap separates frames.

The block also drives an active-low reset line to the coprocessor, so a hung device can be recovered. The synchronous block reset holds that line low.

Top module: `spi_busy_master`

## Requirements
- R1: While `cs_n` is high, `sclk` is low. After reset, `cs_n`=1, `sclk`=0, `mosi`=0 and `ready`=1.
- R2: On a write, `mosi` carries the byte MSB first. Bit 7 is on the line before the first rising `sclk` edge. `mosi` changes only on falling edges, so it is stable at every rising edge.
- R3: On a read, `miso` is sampled on each rising edge, MSB first. The byte appears on `rd_data` with `rd_valid` high for exactly one cycle, in the cycle in which `cs_n` returns high. `mosi` stays 0 for the whole read, and a write never raises `rd_valid`.
- R4: A write frame begins only while the synchronized `busy` is 1. A write requested while `busy` is 0 is held, not dropped, and runs once `busy` goes high.
- R5: A read frame begins only while the synchronized `busy` is 0. A read requested while `busy` is 1 is held and runs once `busy` goes low.
- R6: `sclk` is high for `DIV` clock cycles and low for `DIV` clock cycles, which gives a period of `2*DIV` cycles.
- R7: `cs_n` falls `DIV` cycles before the first rising edge and rises `DIV` cycles after the last falling edge. It then stays high for at least `2*DIV` cycles before the next frame.
- R8: `ready` is high only while idle. It drops in the cycle after a request is accepted and stays low until the frame and its idle gap end. Requests made while `ready` is 0 have no effect.
- R9: If `wr_req` and `rd_req` are both high in the same accepting cycle, the write is taken and the read is discarded.
- R10: `slave_rst_n` is 0 in every cycle after an edge on which `rst` was 1. It is 1 in the first cycle after reset is released.
- R11: When `busy` has been stable in the permitting level for at least two cycles, `cs_n` falls on the clock edge after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Request to send `wr_data` to the coprocessor |
| wr_data | input | 8 | Byte to send |
| rd_req | input | 1 | Request to fetch one byte from the coprocessor |
| ready | output | 1 | Idle and able to accept a request |
| rd_data | output | 8 | Last byte received |
| rd_valid | output | 1 | One-cycle strobe marking a new `rd_data` |
| busy | input | 1 | Direction line from the coprocessor (asynchronous) |
| miso | input | 1 | Serial data from the coprocessor |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the coprocessor |
| cs_n | output | 1 | Chip select, active low |
| slave_rst_n | output | 1 | Reset line to the coprocessor, active low |

## Verification
Every result has a fixed offset from its trigger. `ready` falls one cycle after the accepting edge. `cs_n` falls one further cycle later when `busy` already permits the transfer, and two to three cycles after a `busy` change otherwise. The first rising edge comes `DIV` cycles after `cs_n` falls, and `rd_valid` coincides with the rise of `cs_n`.

The bench drives inputs on falling clock edges and samples ports at the falling edge that follows the expected rising edge. It timestamps serial edges from a slave model to measure the widths and margins of R6 and R7. For held requests, it waits well past the synchronizer delay with `busy` in the blocking level. It then confirms that `cs_n` never fell and that no frame was counted before releasing `busy`.

// File: rtl/spi_busy_pkg.sv
package spi_busy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SETUP,
        ST_XFER,
        ST_HOLD,
        ST_GAP
    } st_e;

    typedef struct packed {
        st_e        st;
        logic       is_rd;
        logic [7:0] tx;
        logic [7:0] rx;
        logic [2:0] nbit;
        logic       gap;
        logic       sclk;
        logic       mosi;
        logic       cs_n;
        logic [7:0] rd_data;
        logic       rd_valid;
        logic       srst_n;
    } regs_t;

endpackage

// File: rtl/spi_busy_sync.sv
module spi_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)               cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/spi_busy_master.sv
module spi_busy_master
    import spi_busy_pkg::*;
#(
    parameter int DIV       = 4,
    parameter int SYNC_LEN  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_req,
    input  logic [7:0] wr_data,
    input  logic       rd_req,
    output logic       ready,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    input  logic       busy,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n,
    output logic       slave_rst_n
);
    localparam logic [2:0] LAST_BIT = 3'd7;

    localparam regs_t RESET_VAL = '{
        st:       ST_IDLE,
        is_rd:    1'b0,
        tx:       8'h00,
        rx:       8'h00,
        nbit:     3'd0,
        gap:      1'b0,
        sclk:     1'b0,
        mosi:     1'b0,
        cs_n:     1'b1,
        rd_data:  8'h00,
        rd_valid: 1'b0,
        srst_n:   1'b0
    };

    regs_t r_d, r_q;
    logic  busy_s;
    logic  tick;
    logic  run;
    logic  dir_ok;

    spi_busy_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (busy),
        .q   (busy_s)
    );

    assign run = (r_q.st == ST_SETUP) || (r_q.st == ST_XFER) ||
                 (r_q.st == ST_HOLD)  || (r_q.st == ST_GAP);

    spi_half_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    // write needs busy high, read needs busy low
    assign dir_ok = r_q.is_rd ? !busy_s : busy_s;

    always_comb begin
        r_d          = r_q;
        r_d.rd_valid = 1'b0;
        r_d.srst_n   = 1'b1;
        unique case (r_q.st)
            ST_IDLE: begin
                if (wr_req) begin
                    r_d.tx    = wr_data;
                    r_d.is_rd = 1'b0;
                    r_d.st    = ST_WAIT;
                end else if (rd_req) begin
                    r_d.tx    = 8'h00;
                    r_d.is_rd = 1'b1;
                    r_d.st    = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (dir_ok) begin
                    r_d.st   = ST_SETUP;
                    r_d.cs_n = 1'b0;
                    r_d.mosi = r_q.tx[7];
                    r_d.nbit = 3'd0;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    r_d.sclk = 1'b1;
                    r_d.rx   = {r_q.rx[6:0], miso};
                    r_d.st   = ST_XFER;
                end
            end
            ST_XFER: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk = 1'b1;
                        r_d.rx   = {r_q.rx[6:0], miso};
                    end else begin
                        r_d.sclk = 1'b0;
                        if (r_q.nbit == LAST_BIT) begin
                            r_d.mosi = 1'b0;
                            r_d.st   = ST_HOLD;
                        end else begin
                            r_d.nbit = r_q.nbit + 1'b1;
                            r_d.tx   = {r_q.tx[6:0], 1'b0};
                            r_d.mosi = r_q.tx[6];
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    r_d.cs_n = 1'b1;
                    r_d.gap  = 1'b0;
                    r_d.st   = ST_GAP;
                    if (r_q.is_rd) begin
                        r_d.rd_data  = r_q.rx;
                        r_d.rd_valid = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (r_q.gap) r_d.st  = ST_IDLE;
                    else         r_d.gap = 1'b1;
                end
            end
            default: r_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= RESET_VAL;
        else     r_q <= r_d;
    end

    assign ready       = (r_q.st == ST_IDLE);
    assign rd_data     = r_q.rd_data;
    assign rd_valid    = r_q.rd_valid;
    assign sclk        = r_q.sclk;
    assign mosi        = r_q.mosi;
    assign cs_n        = r_q.cs_n;
    assign slave_rst_n = r_q.srst_n;
endmodule

// File: rtl/spi_busy_master_chk.sv
module spi_busy_master_chk (
    input logic clk,
    input logic rst,
    input logic ready,
    input logic rd_valid,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic slave_rst_n
);
    AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk); // R1
    AST_MOSI_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(mosi)); // R2
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R3
    AST_VALID_ON_DESELECT: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $rose(cs_n)); // R3
    AST_SELECT_FROM_REST: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (!sclk && !ready)); // R7
    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        ready |-> (cs_n && !sclk)); // R8
    AST_SLAVE_RESET_HELD: assert property (@(posedge clk)
        rst |=> !slave_rst_n); // R10
endmodule

bind spi_busy_master spi_busy_master_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ready       (ready),
    .rd_valid    (rd_valid),
    .sclk        (sclk),
    .mosi        (mosi),
    .cs_n        (cs_n),
    .slave_rst_n (slave_rst_n)
);

// File: tb/spi_busy_master_tb.sv
`timescale 1ns/1ps
module spi_busy_master_tb;
    localparam int DIV = 4;
    localparam int TCK = 8;
    localparam int HALF_NS = DIV * TCK;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_req = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_req = 1'b0;
    logic       ready;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       busy = 1'b1;
    logic       miso = 1'b0;
    logic       sclk;
    logic       mosi;
    logic       cs_n;
    logic       slave_rst_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(TCK/2) clk = ~clk;

    spi_busy_master #(.DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(wr_data),
        .rd_req(rd_req), .ready(ready), .rd_data(rd_data),
        .rd_valid(rd_valid), .busy(busy), .miso(miso), .sclk(sclk),
        .mosi(mosi), .cs_n(cs_n), .slave_rst_n(slave_rst_n)
    );

    // slave model and edge timing monitor
    logic [7:0] slv_byte = 8'h00;
    logic [7:0] slv_sh = 8'h00;
    logic [7:0] seen_mosi = 8'h00;
    int  frames = 0;
    int  tim_err = 0;
    bit  in_frame = 1'b0;
    bit  first_rise = 1'b0;
    time t_cs_fall = 0, t_cs_rise = 0, t_rise = 0, t_fall = 0;

    always @(negedge cs_n) begin
        if (frames > 0 && ($time - t_cs_rise) < 2*HALF_NS) tim_err++; // R7 gap
        t_cs_fall  = $time;
        in_frame   = 1'b1;
        first_rise = 1'b1;
        slv_sh     = slv_byte;
        miso       = slv_byte[7];
    end

    always @(posedge sclk) begin
        if (first_rise) begin
            if (($time - t_cs_fall) != HALF_NS) tim_err++; // R7 setup
        end else if (($time - t_rise) != 2*HALF_NS) tim_err++; // R6
        first_rise = 1'b0;
        t_rise     = $time;
        seen_mosi  = {seen_mosi[6:0], mosi};
    end

    always @(negedge sclk) begin
        if (in_frame) begin
            if (($time - t_rise) != HALF_NS) tim_err++; // R6 high width
            t_fall = $time;
            slv_sh = {slv_sh[6:0], 1'b0};
            miso   = slv_sh[7];
        end
    end

    always @(posedge cs_n) begin
        if (in_frame) begin
            if (($time - t_fall) != HALF_NS) tim_err++; // R7 hold
            t_cs_rise = $time;
            in_frame  = 1'b0;
            frames++;
        end
    end

    // strobe monitor
    int   n_valid = 0;
    int   valid_err = 0;
    logic [7:0] got_rd = 8'h00;
    logic prev_valid = 1'b0;
    logic prev_cs = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin
                n_valid++;
                got_rd = rd_data;
                if (prev_valid || prev_cs !== 1'b0 || cs_n !== 1'b1) valid_err++;
            end
            prev_valid = rd_valid;
            prev_cs    = cs_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!ready);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        idle(3);
        check(slave_rst_n == 1'b0, "R10 held", slave_rst_n, 0);
        check(cs_n == 1'b1 && sclk == 1'b0, "R1 reset lines", {cs_n, sclk}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        check(slave_rst_n == 1'b1, "R10 release", slave_rst_n, 1);
        check(ready == 1'b1 && mosi == 1'b0, "R1 ready", {ready, mosi}, 2'b10);
    endtask

    task automatic t_write(input logic [7:0] b);
        int f0 = frames;
        int v0 = n_valid;
        busy = 1'b1;
        idle(3);
        wait_ready();
        wr_req = 1'b1; wr_data = b;
        @(negedge clk);
        wr_req = 1'b0;
        check(ready == 1'b0 && cs_n == 1'b1, "R8 drop", {ready, cs_n}, 2'b01);
        @(negedge clk);
        check(cs_n == 1'b0, "R11 select latency", cs_n, 0);
        wait_ready();
        check(seen_mosi == b, "R2 write byte", seen_mosi, b);
        check(frames == f0 + 1, "R2 one frame", frames, f0 + 1);
        check(n_valid == v0, "R3 no strobe on write", n_valid, v0);
    endtask

    task automatic t_read(input logic [7:0] b);
        int v0 = n_valid;
        busy = 1'b0;
        slv_byte = b;
        idle(3);
        wait_ready();
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        @(negedge clk);
        check(cs_n == 1'b0, "R11 read select", cs_n, 0);
        wait_ready();
        check(got_rd == b, "R3 read byte", got_rd, b);
        check(n_valid == v0 + 1, "R3 one strobe", n_valid, v0 + 1);
        check(seen_mosi == 8'h00, "R3 mosi zero", seen_mosi, 0);
    endtask

    task automatic t_write_held(input logic [7:0] b);
        int f0 = frames;
        busy = 1'b0;
        idle(3);
        wait_ready();
        wr_req = 1'b1; wr_data = b;
        @(negedge clk);
        wr_req = 1'b0;
        idle(40);
        check(cs_n == 1'b1 && frames == f0, "R4 gated", frames, f0);
        check(ready == 1'b0, "R4 held pending", ready, 0);
        busy = 1'b1;
        wait_ready();
        check(frames == f0 + 1 && seen_mosi == b, "R4 sent later", seen_mosi, b);
    endtask

    task automatic t_read_held(input logic [7:0] b);
        int f0 = frames;
        busy = 1'b1;
        slv_byte = b;
        idle(3);
        wait_ready();
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        idle(40);
        check(cs_n == 1'b1 && frames == f0, "R5 gated", frames, f0);
        busy = 1'b0;
        wait_ready();
        check(frames == f0 + 1 && got_rd == b, "R5 read later", got_rd, b);
    endtask

    task automatic t_both(input logic [7:0] b);
        int v0 = n_valid;
        busy = 1'b1;
        idle(3);
        wait_ready();
        wr_req = 1'b1; rd_req = 1'b1; wr_data = b;
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0;
        wait_ready();
        idle(60);
        check(seen_mosi == b && n_valid == v0, "R9 write wins", seen_mosi, b);
    endtask

    task automatic t_ignored();
        int f0 = frames;
        busy = 1'b1;
        idle(3);
        wait_ready();
        wr_req = 1'b1; wr_data = 8'h55;
        @(negedge clk);
        wr_data = 8'hFF;
        idle(10);
        wr_req = 1'b0;
        wait_ready();
        idle(100);
        check(frames == f0 + 1, "R8 busy request ignored", frames, f0 + 1);
        check(seen_mosi == 8'h55, "R8 data kept", seen_mosi, 8'h55);
    endtask

    task automatic t_back_to_back();
        busy = 1'b1;
        idle(3);
        for (int i = 0; i < 3; i++) begin
            wait_ready();
            wr_req = 1'b1; wr_data = 8'(8'h11 * (i + 1));
            @(negedge clk);
            wr_req = 1'b0;
        end
        wait_ready();
        check(seen_mosi == 8'h33, "R7 back to back", seen_mosi, 8'h33);
    endtask

    initial begin
        t_reset();
        t_write(8'hA5);
        t_write(8'h3C);
        t_write(8'h80);
        t_write(8'h01);
        t_read(8'h96);
        t_read(8'hFF);
        t_read(8'h01);
        t_write_held(8'hC3);
        t_read_held(8'h5A);
        t_both(8'h7E);
        t_ignored();
        t_back_to_back();
        check(tim_err == 0, "R6 R7 edge timing", tim_err, 0);
        check(valid_err == 0, "R3 strobe shape", valid_err, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * TCK);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule